// File: doc/BRIEF.md
# Expansion-Bus Cycle Sequencer

This block watches the command strobes of a parallel expansion bus and its address-enable line. It classifies each bus cycle as one of four types: I/O read, I/O write, memory read or memory write. It then runs the transceiver controls for that cycle. The shared address/data multiplexer shows the address side by default and is switched to the data side for writes. A data output enable drives read data onto the bus. The bus ready line can be pulled low while an attached register block asks for wait states.

The strobes and address-enable are asynchronous to the local clock, so they first pass through a synchroniser. A combinational classifier then looks at the synchronised levels. A state machine walks each accepted cycle through six states:

- IDLE: waiting for a legal pattern.
- START: one-cycle start strobe.
- WAIT: held while the ready-hold input is high.
- SAMPLE: one-cycle sample strobe.
- HOLD: waiting until all four strobes are high again.
- FINISH: one-cycle done strobe, then back to IDLE.

The transitions are:

- IDLE to START when a legal pattern is seen.
- START to WAIT unconditionally.
- WAIT to SAMPLE once ready-hold is low.
- SAMPLE to HOLD unconditionally.
- HOLD to FINISH once all four strobes are high.
- FINISH to IDLE unconditionally.

Attached register blocks use the start, sample and done strobes together with the cycle-type code.

Top module: `bus_cycle_seq`

## Requirements
- R1: With address-enable low, the I/O-read strobe low and the other three strobes high, a cycle of type code 1 (I/O read) is started.
- R2: With address-enable low, the I/O-write strobe low and the other three strobes high, a cycle of type code 2 (I/O write) is started.
- R3: A memory-read strobe low with the other three high starts type code 3, and a memory-write strobe low with the other three high starts type code 4. Both are recognised at either level of address-enable.
- R4: Any other combination starts no cycle: cyc_start stays low and cyc_kind stays 0. This includes two or more strobes low, and an I/O strobe with address-enable high.
- R5: Each input passes through two synchronising flops. cyc_start is still low in the cycle after the second clock edge that follows a change to a legal pattern, and is high after the third edge.
- R6: For read cycles (codes 1 and 3), data_oe is high from START through HOLD, and the multiplexer stays on the address side (mux_data_sel = 0). data_oe is low again when cyc_done pulses.
- R7: For write cycles (codes 2 and 4), mux_data_sel is 1 (data side) from START through HOLD, and data_oe stays low. mux_data_sel is back at 0 when cyc_done pulses.
- R8: While ready_hold is high in START or WAIT, chrdy is low and no sample strobe is issued. cyc_sample pulses on the cycle after the edge at which ready_hold is seen low.
- R9: The sequencer stays in HOLD, with no cyc_done, for as long as any of the four synchronised strobes is low.
- R10: Each accepted cycle gives exactly one single-cycle pulse on each of cyc_start, cyc_sample and cyc_done, in that order. cyc_kind returns to 0 after cyc_done.
- R11: After reset the block is idle: cyc_kind = 0, data_oe = 0, mux_data_sel = 0, chrdy = 1, and all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | Bus address-enable (async) |
| ior_n | input | 1 | I/O read strobe, active low (async) |
| iow_n | input | 1 | I/O write strobe, active low (async) |
| memr_n | input | 1 | Memory read strobe, active low (async) |
| memw_n | input | 1 | Memory write strobe, active low (async) |
| ready_hold | input | 1 | Wait-state request from an attached block |
| mux_data_sel | output | 1 | 1 = multiplexer shows data, 0 = address |
| data_oe | output | 1 | Drive read data onto the bus |
| chrdy | output | 1 | Bus ready line, low requests wait states |
| cyc_kind | output | 3 | Current cycle type: 0 none, 1 I/O read, 2 I/O write, 3 mem read, 4 mem write |
| cyc_start | output | 1 | One-cycle pulse when a cycle is accepted |
| cyc_sample | output | 1 | One-cycle pulse when data may be taken or must be valid |
| cyc_done | output | 1 | One-cycle pulse when the bus cycle has ended |

## Verification
The single-strobe patterns are applied for all four cycle types. Memory types are tried at both address-enable levels, which separates the gated I/O decode from the ungated memory decode. Patterns with two strobes low, and I/O strobes with address-enable high, must start nothing; this separates exact-pattern matching from single-strobe detection. Long strobe holds and long ready_hold requests separate the HOLD and WAIT conditions from fixed-length sequencing, and the start latency pins down the synchroniser depth.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int NUM_STROBES = 4;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_IOR  = 3'd1,
        KIND_IOW  = 3'd2,
        KIND_MEMR = 3'd3,
        KIND_MEMW = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_WAIT,
        S_SAMPLE,
        S_HOLD,
        S_FINISH
    } seq_state_e;

    // bit order of the strobe vector: {memw_n, memr_n, iow_n, ior_n}
    localparam int IDX_IOR  = 0;
    localparam int IDX_IOW  = 1;
    localparam int IDX_MEMR = 2;
    localparam int IDX_MEMW = 3;
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= RESET_VAL;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= RESET_VAL;
                end else begin
                    stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

    // R5: the output stage follows the stage before it one edge later
    assert_sync_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[STAGES-1] == $past(stage_q[STAGES-2])));
endmodule

// File: rtl/bcs_decode.sv
module bcs_decode
    import bcs_pkg::*;
(
    input  logic                   aen_s,
    input  logic [NUM_STROBES-1:0] strb_n_s,
    output cyc_kind_e              kind_o,
    output logic                   all_idle_o
);
    logic [NUM_STROBES-1:0] only_low [NUM_STROBES];

    generate
        for (genvar i = 0; i < NUM_STROBES; i++) begin : g_pat
            // exactly strobe i low, every other strobe high
            assign only_low[i] = ~(NUM_STROBES'(1) << i);
        end
    endgenerate

    always_comb begin
        kind_o = KIND_NONE;
        if (!aen_s && strb_n_s == only_low[IDX_IOR]) begin
            kind_o = KIND_IOR;
        end else if (!aen_s && strb_n_s == only_low[IDX_IOW]) begin
            kind_o = KIND_IOW;
        end else if (strb_n_s == only_low[IDX_MEMR]) begin
            kind_o = KIND_MEMR;
        end else if (strb_n_s == only_low[IDX_MEMW]) begin
            kind_o = KIND_MEMW;
        end
    end

    assign all_idle_o = &strb_n_s;
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind_in,
    input  logic      strobes_idle,
    input  logic      ready_hold,
    output logic      mux_data_sel,
    output logic      data_oe,
    output logic      chrdy,
    output cyc_kind_e cyc_kind,
    output logic      cyc_start,
    output logic      cyc_sample,
    output logic      cyc_done
);
    seq_state_e state, state_nxt;
    cyc_kind_e  cur_kind;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:   if (kind_in != KIND_NONE) state_nxt = S_START;
            S_START:  state_nxt = S_WAIT;
            S_WAIT:   if (!ready_hold) state_nxt = S_SAMPLE;
            S_SAMPLE: state_nxt = S_HOLD;
            S_HOLD:   if (strobes_idle) state_nxt = S_FINISH;
            S_FINISH: state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_kind <= KIND_NONE;
        end else begin
            state <= state_nxt;
            if (state == S_IDLE && kind_in != KIND_NONE) begin
                cur_kind <= kind_in;
            end else if (state == S_FINISH) begin
                cur_kind <= KIND_NONE;
            end
        end
    end

    always_comb begin
        logic in_cycle;
        logic is_read;
        logic is_write;
        in_cycle     = 1'b0;
        is_read      = (cur_kind == KIND_IOR) || (cur_kind == KIND_MEMR);
        is_write     = (cur_kind == KIND_IOW) || (cur_kind == KIND_MEMW);
        cyc_start    = 1'b0;
        cyc_sample   = 1'b0;
        cyc_done     = 1'b0;
        chrdy        = 1'b1;
        unique case (state)
            S_IDLE:   in_cycle = 1'b0;
            S_START:  begin in_cycle = 1'b1; cyc_start = 1'b1; chrdy = !ready_hold; end
            S_WAIT:   begin in_cycle = 1'b1; chrdy = !ready_hold; end
            S_SAMPLE: begin in_cycle = 1'b1; cyc_sample = 1'b1; end
            S_HOLD:   in_cycle = 1'b1;
            S_FINISH: cyc_done = 1'b1;
            default:  in_cycle = 1'b0;
        endcase
        data_oe      = in_cycle && is_read;
        mux_data_sel = in_cycle && is_write;
        cyc_kind     = cur_kind;
    end

    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);
    assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (cyc_kind == KIND_NONE));
    assert_hold_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !strobes_idle) |=> !cyc_done);
    assert_ready_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && ready_hold) |=> !cyc_sample);
    assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && kind_in == KIND_NONE) |=> !cyc_start);
    assert_oe_vs_mux_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !mux_data_sel);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aen,
    input  logic       ior_n,
    input  logic       iow_n,
    input  logic       memr_n,
    input  logic       memw_n,
    input  logic       ready_hold,
    output logic       mux_data_sel,
    output logic       data_oe,
    output logic       chrdy,
    output logic [2:0] cyc_kind,
    output logic       cyc_start,
    output logic       cyc_sample,
    output logic       cyc_done
);
    localparam int SYNC_W = NUM_STROBES + 1;

    logic [SYNC_W-1:0]      raw_in;
    logic [SYNC_W-1:0]      sync_in;
    logic [NUM_STROBES-1:0] strb_s;
    logic                   aen_s;
    cyc_kind_e              kind_dec;
    cyc_kind_e              kind_out;
    logic                   all_idle;

    assign raw_in = {aen, memw_n, memr_n, iow_n, ior_n};

    bcs_sync #(
        .WIDTH     (SYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign aen_s  = sync_in[SYNC_W-1];
    assign strb_s = sync_in[NUM_STROBES-1:0];

    bcs_decode u_dec (
        .aen_s      (aen_s),
        .strb_n_s   (strb_s),
        .kind_o     (kind_dec),
        .all_idle_o (all_idle)
    );

    bcs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind_in      (kind_dec),
        .strobes_idle (all_idle),
        .ready_hold   (ready_hold),
        .mux_data_sel (mux_data_sel),
        .data_oe      (data_oe),
        .chrdy        (chrdy),
        .cyc_kind     (kind_out),
        .cyc_start    (cyc_start),
        .cyc_sample   (cyc_sample),
        .cyc_done     (cyc_done)
    );

    assign cyc_kind = kind_out;
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic aen = 1'b1, ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic ready_hold = 1'b0;
    logic mux_data_sel, data_oe, chrdy, cyc_start, cyc_sample, cyc_done;
    logic [2:0] cyc_kind;

    int n_checks = 0;
    int n_fail = 0;
    int start_cnt = 0;
    int sample_cnt = 0;
    int done_cnt = 0;
    int exp_q[$];
    int mon_k;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
        .memr_n(memr_n), .memw_n(memw_n), .ready_hold(ready_hold),
        .mux_data_sel(mux_data_sel), .data_oe(data_oe), .chrdy(chrdy),
        .cyc_kind(cyc_kind), .cyc_start(cyc_start), .cyc_sample(cyc_sample),
        .cyc_done(cyc_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit is_rd(input int k);
        return (k == 1) || (k == 3);
    endfunction

    function automatic bit is_wr(input int k);
        return (k == 2) || (k == 4);
    endfunction

    // monitor: pops expected cycle types as the design reports them
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_start) start_cnt++;
            if (cyc_sample) begin
                sample_cnt++;
                chk(exp_q.size() > 0, "R10 sample without queued cycle", exp_q.size(), 1);
                if (exp_q.size() > 0) begin
                    mon_k = exp_q[0];
                    chk(int'(cyc_kind) == mon_k, "R1/R2/R3 kind at sample", int'(cyc_kind), mon_k);
                    chk(data_oe == is_rd(mon_k), "R6 data_oe at sample", int'(data_oe), int'(is_rd(mon_k)));
                    chk(mux_data_sel == is_wr(mon_k), "R7 mux at sample", int'(mux_data_sel), int'(is_wr(mon_k)));
                end
            end
            if (cyc_done) begin
                done_cnt++;
                if (exp_q.size() > 0) begin
                    mon_k = exp_q.pop_front();
                    chk(int'(cyc_kind) == mon_k, "R10 kind at done", int'(cyc_kind), mon_k);
                end else begin
                    chk(1'b0, "R10 done without queued cycle", 0, 1);
                end
                chk(!data_oe && !mux_data_sel, "R6/R7 released at done",
                    int'({data_oe, mux_data_sel}), 0);
            end
        end
    end

    task automatic drive(input bit a, input logic [3:0] s);
        @(posedge clk); #2;
        aen = a;
        {memw_n, memr_n, iow_n, ior_n} = s;
    endtask

    // run one legal cycle; kind 1..4, strobe vector {memw,memr,iow,ior}
    task automatic run_cycle(input int kind, input bit a, input logic [3:0] s,
                             input int wait_cyc, input int hold_cyc);
        int s0, sm0, d0;
        s0 = start_cnt; sm0 = sample_cnt; d0 = done_cnt;
        exp_q.push_back(kind);
        if (wait_cyc > 0) ready_hold = 1'b1;
        drive(a, s);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cyc_start == 1'b0, "R5 start not before third edge", int'(cyc_start), 0);
        @(posedge clk);
        @(negedge clk);
        chk(cyc_start == 1'b1, "R5 start after third edge", int'(cyc_start), 1);
        if (wait_cyc > 0) begin
            repeat (wait_cyc) @(posedge clk);
            @(negedge clk);
            chk(chrdy == 1'b0, "R8 chrdy low while held", int'(chrdy), 0);
            chk(sample_cnt == sm0, "R8 no sample while held", sample_cnt, sm0);
            @(posedge clk); #2;
            ready_hold = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(cyc_sample == 1'b1, "R8 sample after release", int'(cyc_sample), 1);
            chk(chrdy == 1'b1, "R8 chrdy high after release", int'(chrdy), 1);
        end
        repeat (hold_cyc) @(posedge clk);
        @(negedge clk);
        chk(done_cnt == d0, "R9 no done while strobe low", done_cnt, d0);
        if (is_wr(kind))
            chk(mux_data_sel == 1'b1, "R7 mux data side in hold", int'(mux_data_sel), 1);
        else
            chk(data_oe == 1'b1, "R6 data_oe on in hold", int'(data_oe), 1);
        drive(1'b1, 4'b1111);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(start_cnt == s0 + 1, "R10 one start", start_cnt, s0 + 1);
        chk(sample_cnt == sm0 + 1, "R10 one sample", sample_cnt, sm0 + 1);
        chk(done_cnt == d0 + 1, "R10 one done", done_cnt, d0 + 1);
        chk(cyc_kind == 3'd0, "R10 kind cleared", int'(cyc_kind), 0);
    endtask

    task automatic run_illegal(input bit a, input logic [3:0] s);
        int s0;
        s0 = start_cnt;
        drive(a, s);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(start_cnt == s0, "R4 no start on illegal pattern", start_cnt, s0);
        chk(cyc_kind == 3'd0, "R4 kind stays none", int'(cyc_kind), 0);
        drive(1'b1, 4'b1111);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(cyc_kind == 3'd0 && !data_oe && !mux_data_sel && chrdy,
            "R11 idle outputs after reset", int'({cyc_kind, data_oe, mux_data_sel, chrdy}), 1);
        chk(!cyc_start && !cyc_sample && !cyc_done, "R11 strobes low after reset",
            int'({cyc_start, cyc_sample, cyc_done}), 0);

        run_cycle(1, 1'b0, 4'b1110, 0, 5);   // R1 I/O read
        run_cycle(2, 1'b0, 4'b1101, 0, 5);   // R2 I/O write
        run_cycle(3, 1'b0, 4'b1011, 0, 5);   // R3 mem read, aen low
        run_cycle(3, 1'b1, 4'b1011, 0, 7);   // R3 mem read, aen high
        run_cycle(4, 1'b1, 4'b0111, 0, 5);   // R3 mem write, aen high
        run_cycle(4, 1'b0, 4'b0111, 0, 20);  // R3/R9 mem write, long hold

        run_illegal(1'b1, 4'b1110);          // R4 I/O read with aen high
        run_illegal(1'b1, 4'b1101);          // R4 I/O write with aen high
        run_illegal(1'b0, 4'b1100);          // R4 two strobes low
        run_illegal(1'b0, 4'b0011);          // R4 two memory strobes low
        run_illegal(1'b0, 4'b0000);          // R4 all strobes low

        run_cycle(1, 1'b0, 4'b1110, 12, 5);  // R8 wait states on a read
        run_cycle(2, 1'b0, 4'b1101, 3, 30);  // R8/R9 wait states then long write

        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule